// File: doc/BRIEF.md
# Associative Store Buffer with Load Forwarding

This block sits between the processor's store path and main memory in a write-through data cache. Stores land in a small fully associative buffer and are held there until the memory arbiter can take them. The buffer then hands them on one word at a time, oldest first. A store to an address that is already buffered updates that entry in place. A load presents its address to a lookup port; if a buffered entry matches, the buffered word is returned and the cache contents are not used.

The drain side uses a plain request/accept handshake. Each accepted word is also flagged with a cache-update strobe, so the cache can refresh its copy when the line is resident. A full indication lets the arbiter give the buffer the highest priority when no space is left.

Top module: `wbuf_top`

## Requirements
- R1: After reset the buffer is empty. `dr_req_o`, `full_o`, `st_stall_o`, `ld_hit_o` and `dr_cache_upd_o` are all low.
- R2: `ld_hit_o` is high and `ld_data_o` carries the buffered word when `ld_addr_i` equals the address of a valid entry. `ld_hit_o` is low for any other address.
- R3: A store whose address equals that of a valid entry which is not being drained in the same cycle replaces that entry's data and takes no new slot. The store is accepted even when the buffer is full.
- R4: A store with no matching entry takes a free slot. `full_o` is high while all four slots are occupied. A non-matching store made while the buffer is full and no drain is accepted is stalled (`st_stall_o` high), is not recorded, and later loads to its address miss.
- R5: `dr_req_o` is high whenever the buffer is non-empty. `dr_addr_o`/`dr_data_o` then show the oldest entry, and a cycle with `dr_accept_i` high removes that entry.
- R6: `dr_cache_upd_o` is high exactly in the cycles where a word is handed over (`dr_req_o` and `dr_accept_i` both high).
- R7: A store merged into an existing entry does not move that entry in the drain order.
- R8: When the buffer is full and a drain is accepted in the same cycle, a non-matching store is accepted into the freed slot without stalling.
- R9: A store to the address of the entry that is being drained in the same cycle gets a new slot. The drain hands over the old data, and the new data is drained later as a separate word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store present this cycle |
| st_addr_i | input | 32 | Store word address |
| st_data_i | input | 32 | Store data |
| st_stall_o | output | 1 | Store not accepted this cycle |
| ld_addr_i | input | 32 | Load lookup address |
| ld_hit_o | output | 1 | Load address found in buffer |
| ld_data_o | output | 32 | Forwarded data |
| dr_req_o | output | 1 | Oldest word ready to drain |
| dr_addr_o | output | 32 | Address of oldest word |
| dr_data_o | output | 32 | Data of oldest word |
| dr_accept_i | input | 1 | Arbiter takes the offered word |
| dr_cache_upd_o | output | 1 | Strobe to update a resident cache line |
| full_o | output | 1 | All slots occupied |

## Verification
The bench builds the block with its default parameters: four slots and 32-bit addresses and data. With four slots, four distinct stores fill the buffer. That brings the full-buffer corners within a few cycles: a stall with no drain, slot reuse during a same-cycle drain, and a merge that is accepted while full. The default ring size also places the drained head and the allocation tail on the same slot in the reuse case. The same-address-as-draining-head case is then reached by draining down to the entry that a further store targets.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int unsigned WB_SLOTS  = 4;
    localparam int unsigned WB_ADDR_W = 32;
    localparam int unsigned WB_DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MERGE = 2'd1,
        ST_ALLOC = 2'd2,
        ST_HOLD  = 2'd3
    } st_action_e;
endpackage

// File: rtl/wbuf_cam.sv
module wbuf_cam #(
    parameter int unsigned N  = 4,
    parameter int unsigned AW = 32
) (
    input  logic [N-1:0]         vld_i,
    input  logic [N-1:0][AW-1:0] tag_i,
    input  logic [AW-1:0]        key_i,
    output logic [N-1:0]         hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_o[g] = vld_i[g] && (tag_i[g] == key_i);
    end
endmodule

// File: rtl/wbuf_enc.sv
module wbuf_enc #(
    parameter int unsigned N = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) idx_o = idx_o | IW'(i);
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
    import wbuf_pkg::*;
#(
    parameter int unsigned N  = WB_SLOTS,
    parameter int unsigned AW = WB_ADDR_W,
    parameter int unsigned DW = WB_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid_i,
    input  logic [AW-1:0] st_addr_i,
    input  logic [DW-1:0] st_data_i,
    output logic          st_stall_o,
    input  logic [AW-1:0] ld_addr_i,
    output logic          ld_hit_o,
    output logic [DW-1:0] ld_data_o,
    output logic          dr_req_o,
    output logic [AW-1:0] dr_addr_o,
    output logic [DW-1:0] dr_data_o,
    input  logic          dr_accept_i,
    output logic          dr_cache_upd_o,
    output logic          full_o
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned CW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0]         vld;
        logic [N-1:0][AW-1:0] addr;
        logic [N-1:0][DW-1:0] data;
        logic [IW-1:0]        head;
        logic [IW-1:0]        tail;
        logic [CW-1:0]        cnt;
    } state_t;

    state_t s_q, s_d;

    function automatic logic [IW-1:0] ptr_inc(input logic [IW-1:0] p);
        return (p == IW'(N - 1)) ? '0 : p + IW'(1);
    endfunction

    logic [N-1:0]  st_match_vec, st_match_eff, ld_match_vec, head_oh;
    logic          merge_hit, ld_any, drain_fire;
    logic [IW-1:0] merge_idx, ld_idx;
    st_action_e    action;

    wbuf_cam #(.N(N), .AW(AW)) u_cam_st (
        .vld_i (s_q.vld), .tag_i (s_q.addr), .key_i (st_addr_i), .hit_o (st_match_vec)
    );
    wbuf_cam #(.N(N), .AW(AW)) u_cam_ld (
        .vld_i (s_q.vld), .tag_i (s_q.addr), .key_i (ld_addr_i), .hit_o (ld_match_vec)
    );
    wbuf_enc #(.N(N)) u_enc_st (
        .vec_i (st_match_eff), .any_o (merge_hit), .idx_o (merge_idx)
    );
    wbuf_enc #(.N(N)) u_enc_ld (
        .vec_i (ld_match_vec), .any_o (ld_any), .idx_o (ld_idx)
    );

    assign head_oh      = {{(N-1){1'b0}}, 1'b1} << s_q.head;
    assign drain_fire   = (s_q.cnt != '0) && dr_accept_i;
    assign st_match_eff = st_match_vec & ~(drain_fire ? head_oh : '0);

    always_comb begin
        if (!st_valid_i)                              action = ST_IDLE;
        else if (merge_hit)                           action = ST_MERGE;
        else if ((s_q.cnt != CW'(N)) || drain_fire)   action = ST_ALLOC;
        else                                          action = ST_HOLD;
    end

    always_comb begin
        s_d = s_q;
        if (drain_fire) begin
            s_d.vld[s_q.head] = 1'b0;
            s_d.head          = ptr_inc(s_q.head);
        end
        case (action)
            ST_MERGE: s_d.data[merge_idx] = st_data_i;
            ST_ALLOC: begin
                s_d.vld[s_q.tail]  = 1'b1;
                s_d.addr[s_q.tail] = st_addr_i;
                s_d.data[s_q.tail] = st_data_i;
                s_d.tail           = ptr_inc(s_q.tail);
            end
            default: ;
        endcase
        s_d.cnt = s_q.cnt + CW'(action == ST_ALLOC) - CW'(drain_fire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_stall_o     = (action == ST_HOLD);
    assign ld_hit_o       = ld_any;
    assign ld_data_o      = ld_any ? s_q.data[ld_idx] : '0;
    assign dr_req_o       = (s_q.cnt != '0);
    assign dr_addr_o      = s_q.addr[s_q.head];
    assign dr_data_o      = s_q.data[s_q.head];
    assign dr_cache_upd_o = drain_fire;
    assign full_o         = (s_q.cnt == CW'(N));
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
    parameter int unsigned N  = 4,
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid_i,
    input logic          st_stall_o,
    input logic          full_o,
    input logic          dr_req_o,
    input logic          dr_accept_i,
    input logic [AW-1:0] dr_addr_o,
    input logic [N-1:0]  ld_match_vec
);
    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall_o |-> (full_o && !dr_accept_i && st_valid_i)); // R4
    AST_FULL_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> dr_req_o); // R5
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_req_o && !dr_accept_i) |=> (dr_req_o && $stable(dr_addr_o))); // R5
    AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_match_vec)); // R2
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !dr_accept_i) |=> full_o); // R4
endmodule

bind wbuf_top wbuf_chk #(.N(N), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_valid_i   (st_valid_i),
    .st_stall_o   (st_stall_o),
    .full_o       (full_o),
    .dr_req_o     (dr_req_o),
    .dr_accept_i  (dr_accept_i),
    .dr_addr_o    (dr_addr_o),
    .ld_match_vec (ld_match_vec)
);

// File: tb/wbuf_top_tb.sv
module wbuf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid_i = 1'b0;
    logic [31:0] st_addr_i = '0;
    logic [31:0] st_data_i = '0;
    logic        st_stall_o;
    logic [31:0] ld_addr_i = '0;
    logic        ld_hit_o;
    logic [31:0] ld_data_o;
    logic        dr_req_o;
    logic [31:0] dr_addr_o;
    logic [31:0] dr_data_o;
    logic        dr_accept_i = 1'b0;
    logic        dr_cache_upd_o;
    logic        full_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    wbuf_top dut_i (.*);

    localparam logic [63:0] VEC [4] = '{
        {32'h0000_0100, 32'hA000_0001},
        {32'h0000_0204, 32'hB000_0002},
        {32'h0000_0308, 32'hC000_0003},
        {32'h0000_040C, 32'hD000_0004}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] d, input logic acc,
                         output logic stalled, output logic upd);
        @(negedge clk);
        st_valid_i = 1'b1; st_addr_i = a; st_data_i = d; dr_accept_i = acc;
        #1 stalled = st_stall_o; upd = dr_cache_upd_o;
        @(posedge clk); #1;
        st_valid_i = 1'b0; dr_accept_i = 1'b0;
    endtask

    task automatic drain(input string req, input logic [31:0] ea, input logic [31:0] ed);
        @(negedge clk);
        check(req, {31'd0, dr_req_o}, 32'd1);
        check(req, dr_addr_o, ea);
        check(req, dr_data_o, ed);
        dr_accept_i = 1'b1;
        #1 check("R6", {31'd0, dr_cache_upd_o}, 32'd1);
        @(posedge clk); #1 dr_accept_i = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input logic eh,
                          input logic [31:0] ed);
        @(negedge clk);
        ld_addr_i = a;
        #1 check(req, {31'd0, ld_hit_o}, {31'd0, eh});
        if (eh) check(req, ld_data_o, ed);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic stl, upd;
        repeat (2) @(negedge clk);
        #1;
        // R1 reset state
        check("R1", {31'd0, dr_req_o}, 32'd0);
        check("R1", {31'd0, full_o}, 32'd0);
        check("R1", {31'd0, ld_hit_o}, 32'd0);
        check("R1", {31'd0, dr_cache_upd_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1 check("R1", {31'd0, dr_req_o}, 32'd0);

        // vector walk: fill buffer (R4), then forward each entry (R2)
        for (int i = 0; i < 4; i++) begin
            store(VEC[i][63:32], VEC[i][31:0], 1'b0, stl, upd);
            check("R4", {31'd0, stl}, 32'd0);
        end
        @(negedge clk); #1 check("R4", {31'd0, full_o}, 32'd1);
        check("R6", {31'd0, dr_cache_upd_o}, 32'd0);
        for (int i = 0; i < 4; i++) lookup("R2", VEC[i][63:32], 1'b1, VEC[i][31:0]);
        lookup("R2", 32'h0000_0999, 1'b0, '0);

        // R3 merge while full, no stall
        store(32'h0000_0204, 32'hB1B1_B1B1, 1'b0, stl, upd);
        check("R3", {31'd0, stl}, 32'd0);
        lookup("R3", 32'h0000_0204, 1'b1, 32'hB1B1_B1B1);
        @(negedge clk); #1 check("R3", {31'd0, full_o}, 32'd1);

        // R4 stall when full with no drain; store is dropped
        store(32'h0000_0500, 32'hEEEE_0005, 1'b0, stl, upd);
        check("R4", {31'd0, stl}, 32'd1);
        lookup("R4", 32'h0000_0500, 1'b0, '0);

        // R8 full + drain accept: store goes into the freed slot
        store(32'h0000_0500, 32'hEEEE_0005, 1'b1, stl, upd);
        check("R8", {31'd0, stl}, 32'd0);
        check("R6", {31'd0, upd}, 32'd1);
        lookup("R8", 32'h0000_0500, 1'b1, 32'hEEEE_0005);
        lookup("R5", 32'h0000_0100, 1'b0, '0);
        @(negedge clk); #1 check("R8", {31'd0, full_o}, 32'd1);

        // R7 merged entry kept its place; R5 oldest first
        drain("R7", 32'h0000_0204, 32'hB1B1_B1B1);
        drain("R5", 32'h0000_0308, 32'hC000_0003);

        // R9 store to the head being drained takes a new slot
        @(negedge clk);
        st_valid_i = 1'b1; st_addr_i = 32'h0000_040C; st_data_i = 32'h5555_AAAA;
        dr_accept_i = 1'b1;
        #1 check("R9", dr_addr_o, 32'h0000_040C);
        check("R9", dr_data_o, 32'hD000_0004);
        check("R9", {31'd0, st_stall_o}, 32'd0);
        @(posedge clk); #1 st_valid_i = 1'b0; dr_accept_i = 1'b0;
        drain("R5", 32'h0000_0500, 32'hEEEE_0005);
        drain("R9", 32'h0000_040C, 32'h5555_AAAA);

        @(negedge clk); #1;
        check("R5", {31'd0, dr_req_o}, 32'd0);
        check("R4", {31'd0, full_o}, 32'd0);
        dr_accept_i = 1'b1;
        #1 check("R6", {31'd0, dr_cache_upd_o}, 32'd0);
        @(posedge clk); #1 dr_accept_i = 1'b0;
        lookup("R2", 32'h0000_040C, 1'b0, '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule